// File: doc/BRIEF.md
# Mod-5 and Div-5 Event Counter

This block counts pulses arriving on a single event line that idles low. It does not present one running total. It presents the count as two fields: the remainder after dividing by five, and the quotient. The remainder runs from 0 to 4 and then wraps. The quotient steps forward once each time the remainder wraps.

The block is fully synchronous. The event line is a one-cycle enable, sampled on the rising clock edge. Events may arrive back to back or with any gap between them. A synchronous init input clears both fields. The decision to advance the quotient uses the registered remainder from before the update, so no combinational race decides it.

Top module: `evt_divmod5`

## Requirements
- R1: While rst_n is low, rem_o and quo_o are both 0 after the next rising edge.
- R2: Each sampled event with init_i low moves rem_o one step through the sequence 0,1,2,3,4,0. The new value is visible after that edge.
- R3: quo_o increments by one only when an event is sampled while rem_o equals 4. On any other event it holds its value.
- R4: In a cycle with no event and no init, rem_o and quo_o hold their values.
- R5: init_i high clears rem_o and quo_o to 0 at the next edge.
- R6: When init_i and evt_i are high in the same cycle, the event is ignored and both outputs become 0.
- R7: quo_o is 4 bits wide. The increment taken while it holds 15 wraps it to 0.
- R8: rem_o never holds a value above 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Synchronous clear of both fields, with priority over events |
| evt_i | input | 1 | One-cycle event enable |
| rem_o | output | 3 | Count modulo 5 |
| quo_o | output | 4 | Count divided by 5, modulo 16 |

## Verification
The assertions assume that evt_i and init_i are valid, known levels at each rising edge. They place no limit on how often either is high, so back-to-back events and simultaneous init and event are both legal.

The stimulus drives inputs only on the falling edge and holds each value for whole cycles. It sweeps runs of consecutive events, sparse events and idle gaps, and runs the count past 80 events so the quotient wraps. It also applies init alone and init together with an event at every remainder phase. The bench keeps a running integer count and derives the expected fields with mod and div.

// File: rtl/evt_divmod5.sv
module evt_divmod5 #(
  parameter int MODULUS = 5,
  parameter int REM_W   = 3,
  parameter int QUO_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             evt_i,
  output logic [REM_W-1:0] rem_o,
  output logic [QUO_W-1:0] quo_o
);
  localparam logic [REM_W-1:0] REM_LAST = REM_W'(MODULUS - 1);

  logic [REM_W-1:0] rem_q;
  logic [QUO_W-1:0] quo_q;
  logic             wrap;

  assign wrap = evt_i && (rem_q == REM_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || init_i) begin
      rem_q <= '0;
      quo_q <= '0;
    end else if (evt_i) begin
      rem_q <= wrap ? '0 : rem_q + 1'b1;
      if (wrap) quo_q <= quo_q + 1'b1;
    end
  end

  assign rem_o = rem_q;
  assign quo_o = quo_q;
endmodule

module evt_divmod5_chk #(
  parameter int MODULUS = 5,
  parameter int REM_W   = 3,
  parameter int QUO_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_i,
  input logic             evt_i,
  input logic [REM_W-1:0] rem_o,
  input logic [QUO_W-1:0] quo_o
);
  localparam logic [REM_W-1:0] REM_LAST = REM_W'(MODULUS - 1);
  logic seen;
  always_ff @(posedge clk) seen <= rst_n;

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (rem_o == '0 && quo_o == '0)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !init_i && !evt_i) |=> ($stable(rem_o) && $stable(quo_o))); // R4
  AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !init_i && evt_i && rem_o != REM_LAST) |=>
      (rem_o == $past(rem_o) + 1'b1 && quo_o == $past(quo_o))); // R2
  AST_QUO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !init_i && evt_i && rem_o == REM_LAST) |=>
      (rem_o == '0 && quo_o == QUO_W'($past(quo_o) + 1'b1))); // R3
  AST_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> rem_o <= REM_LAST); // R8
endmodule

bind evt_divmod5 evt_divmod5_chk #(.MODULUS(MODULUS), .REM_W(REM_W), .QUO_W(QUO_W)) chk_i (.*);

// File: tb/evt_divmod5_tb.sv
module evt_divmod5_tb_top;
  logic clk = 0, rst_n = 0, init_i = 0, evt_i = 0;
  logic [2:0] rem_o;
  logic [3:0] quo_o;
  int checks = 0, errors = 0, cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_divmod5 dut_i (.clk, .rst_n, .init_i, .evt_i, .rem_o, .quo_o);

  task automatic check(string req);
    int er = cnt % 5;
    int eq = (cnt / 5) % 16;
    checks++;
    if (rem_o != er[2:0] || quo_o != eq[3:0]) begin
      errors++;
      $display("FAIL %s: rem=%0d quo=%0d expected rem=%0d quo=%0d", req, rem_o, quo_o, er, eq);
    end
  endtask

  task automatic step(bit e, bit i, string req);
    @(negedge clk);
    evt_i = e; init_i = i;
    @(negedge clk);
    if (i) cnt = 0; else if (e) cnt++;
    evt_i = 0; init_i = 0;
    check(req);
  endtask

  task automatic burst(int n, string req);
    @(negedge clk);
    evt_i = 1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cnt++;
      check(req);
    end
    evt_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;
    for (int k = 0; k < 12; k++) step(1, 0, "R2");
    for (int k = 0; k < 4; k++) step(0, 0, "R4");
    step(1, 0, "R3");
    step(0, 1, "R5");
    burst(100, "R7");
    for (int k = 0; k < 30; k++) step(k % 3 == 0, 0, "R3");
    for (int p = 0; p < 5; p++) begin
      for (int k = 0; k < 7 + p; k++) step(1, 0, "R2");
      step(1, 1, "R6");
    end
    burst(79, "R3");
    step(1, 0, "R7");
    burst(7, "R8");
    @(negedge clk); rst_n = 0;
    @(negedge clk); cnt = 0; check("R1");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); errors++; $display("FAIL watchdog: rem=%0d quo=%0d expected completion", rem_o, quo_o); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule